// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking

This block decides which of several master agents may drive a shared parallel bus. Each agent has its own active-low request input and active-low grant output. The arbiter watches the frame, initiator-ready and target-ready signals to find the points at which ownership may change. These points are an idle bus, or the clock in which the final data phase of a transaction completes. At those points it hands the grant to the next requester in rotating order.

While nobody else asks for the bus, the grant stays parked on the agent that holds it. That agent may then start further transactions without requesting again. The one exception is a designated bridge agent. Once the bridge drops its request and no other request is pending, its grant is withdrawn and no grant is asserted. When ownership moves, every grant is deasserted for at least one clock before the new grant appears.

Top module: `rr_park_arbiter`

## Requirements
- R1: While reset is asserted, and after reset until a request is seen, every bit of gnt_n is 1. Reset acts asynchronously and also returns the rotating pointer to agent 0.
- R2: At most one bit of gnt_n is 0 at any time. Bit i of req_n and of gnt_n belongs to agent i.
- R3: A grant bit goes from 1 to 0 only if, in the previous clock, that agent's request was asserted (0) and the bus was at a switch point.
- R4: A grant never moves directly from one agent to another. Between two different owners there is at least one clock with gnt_n all ones.
- R5: gnt_n changes only in the clock after a switch point. A switch point is frame_n=1 with irdy_n=1 (idle), or frame_n=1 with irdy_n=0 and trdy_n=0 (final data phase completing). In every other cycle gnt_n holds its value.
- R6: When no grant is held and requests are present at a switch point, the arbiter grants the first requester found by searching upward, with wraparound, from the agent after the last one granted. The search starts from agent 0 after reset.
- R7: A non-bridge owner keeps its grant while no other agent requests, even after its own request is released.
- R8: If the bridge agent (parameter BRIDGE, default agent 3) holds the grant, and at a switch point no request is asserted at all, its grant is withdrawn in the next clock. While the bridge still requests and no other agent does, it keeps the grant.
- R9: If an owner holds the grant and a different agent requests at a switch point, the owner's grant is deasserted in the next clock. The new grant follows one clock later.
- R10: The clock with frame_n=1, irdy_n=0 and trdy_n=1 is not a switch point. The clock in which trdy_n also goes to 0 is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | AGENTS | Active-low request, bit i from agent i |
| frame_n | input | 1 | Active-low bus frame |
| irdy_n | input | 1 | Active-low initiator ready |
| trdy_n | input | 1 | Active-low target ready |
| gnt_n | output | AGENTS | Registered active-low grant, bit i to agent i |

## Verification
The assertions take the bus handshake to be well formed. An agent drives frame_n low only while it holds the grant or is finishing a transaction it has already begun. A completed final data phase is signalled by frame_n high together with irdy_n and trdy_n low. The stimulus keeps to this. Frame activity is driven only in cycles where some agent owns the bus. Inputs change only at the falling clock edge. Requests are raised by agents that lack a grant, or held by an owner that wants to keep it.

// File: rtl/rr_park_arbiter.sv
module rr_park_arbiter #(
  parameter int AGENTS = 4,
  parameter int BRIDGE = 3,
  localparam int IW = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGENTS-1:0] req_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  output logic [AGENTS-1:0] gnt_n
);

  logic [AGENTS-1:0] req, own, others;
  logic [IW-1:0]     ptr, pick;
  logic [IW:0]       slot;
  logic              pick_ok, may_switch, owned, bridge_release;

  assign req            = ~req_n;
  assign may_switch     = frame_n & (irdy_n | ~trdy_n);
  assign others         = req & ~own;
  assign owned          = |own;
  assign bridge_release = own[BRIDGE] & ~req[BRIDGE];
  assign gnt_n          = ~own;

  always_comb begin
    pick    = '0;
    pick_ok = 1'b0;
    slot    = '0;
    for (int k = 0; k < AGENTS; k++) begin
      slot = {1'b0, ptr} + (IW+1)'(k);
      if (slot >= (IW+1)'(AGENTS)) slot = slot - (IW+1)'(AGENTS);
      if (!pick_ok && req[slot[IW-1:0]]) begin
        pick_ok = 1'b1;
        pick    = slot[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= '0;
      ptr <= '0;
    end else if (may_switch) begin
      if (owned) begin
        if ((|others) || bridge_release) own <= '0;
      end else if (pick_ok) begin
        own <= AGENTS'(1) << pick;
        ptr <= (pick == IW'(AGENTS-1)) ? '0 : pick + 1'b1;
      end
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(gnt_n) != '1) && (gnt_n != '1)) |-> (gnt_n == $past(gnt_n)));

  // R5
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_n & (irdy_n | ~trdy_n)) |-> $stable(gnt_n));

  // R8
  bridge_unpark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_n & (irdy_n | ~trdy_n) & ~gnt_n[BRIDGE] & (&req_n)) |-> (&gnt_n));

  // R9
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_n & (irdy_n | ~trdy_n) & (gnt_n != '1) & (|(~req_n & gnt_n))) |-> (&gnt_n));

  for (genvar i = 0; i < AGENTS; i++) begin : g_req_chk
    // R3
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt_n[i]) |-> $past(!req_n[i] && frame_n && (irdy_n || !trdy_n)));
  end

endmodule

// File: tb/rr_park_arbiter_tb_top.sv
`timescale 1ns/1ps
module rr_park_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'b1111;
  logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [3:0] gnt_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rr_park_arbiter #(.AGENTS(4), .BRIDGE(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .gnt_n(gnt_n));

  // {req tag[3:0], req_n[3:0], frame_n, irdy_n, trdy_n, expected gnt_n[3:0]}
  localparam int NV = 28;
  localparam logic [14:0] VEC [NV] = '{
    {4'd1,  4'b1111, 3'b111, 4'b1111},  // R1 idle, no request
    {4'd6,  4'b1101, 3'b111, 4'b1101},  // R6 agent1 from ptr 0
    {4'd5,  4'b1111, 3'b011, 4'b1101},  // R5 busy
    {4'd5,  4'b1011, 3'b001, 4'b1101},  // R5 busy data phase
    {4'd10, 4'b1011, 3'b100, 4'b1111},  // R10 final phase, R9 revoke
    {4'd4,  4'b1011, 3'b111, 4'b1011},  // R4 after gap, agent2
    {4'd7,  4'b1111, 3'b111, 4'b1011},  // R7 parked
    {4'd7,  4'b1111, 3'b111, 4'b1011},  // R7 parked
    {4'd9,  4'b1100, 3'b111, 4'b1111},  // R9 revoke
    {4'd6,  4'b1100, 3'b111, 4'b1110},  // R6 from ptr 3 wraps to 0
    {4'd9,  4'b1100, 3'b111, 4'b1111},  // R9 agent1 waiting
    {4'd6,  4'b1100, 3'b111, 4'b1101},  // R6 agent1
    {4'd9,  4'b1110, 3'b111, 4'b1111},  // R9
    {4'd6,  4'b1110, 3'b111, 4'b1110},  // R6 agent0
    {4'd9,  4'b0111, 3'b111, 4'b1111},  // R9 bridge asks
    {4'd6,  4'b0111, 3'b111, 4'b0111},  // R6 bridge granted
    {4'd5,  4'b1111, 3'b011, 4'b0111},  // R5 busy holds bridge
    {4'd8,  4'b1111, 3'b111, 4'b1111},  // R8 bridge unparked
    {4'd8,  4'b1111, 3'b111, 4'b1111},  // R8 stays empty
    {4'd6,  4'b0011, 3'b111, 4'b1011},  // R6 ptr 0 -> agent2
    {4'd5,  4'b0011, 3'b011, 4'b1011},  // R5
    {4'd5,  4'b0011, 3'b001, 4'b1011},  // R5
    {4'd10, 4'b0011, 3'b101, 4'b1011},  // R10 not complete yet
    {4'd10, 4'b0011, 3'b100, 4'b1111},  // R10 complete
    {4'd6,  4'b0011, 3'b111, 4'b0111},  // R6 ptr 3 -> bridge
    {4'd8,  4'b0111, 3'b111, 4'b0111},  // R8 bridge parked while asking
    {4'd9,  4'b1011, 3'b111, 4'b1111},  // R9
    {4'd4,  4'b1011, 3'b111, 4'b1011}   // R4 agent2
  };

  task automatic check(input logic [3:0] exp, input int rq, input string what);
    checks++;
    if (gnt_n !== exp) begin
      errors++;
      $display("FAIL R%0d %s: gnt_n=%b expected %b", rq, what, gnt_n, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    check(4'b1111, 1, "in reset");  // R1
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req_n   = VEC[v][10:7];
      frame_n = VEC[v][6];
      irdy_n  = VEC[v][5];
      trdy_n  = VEC[v][4];
      @(posedge clk);
      #1;
      check(VEC[v][3:0], int'(VEC[v][14:11]), $sformatf("vector %0d", v));
    end
    // R1 asynchronous reset while agent2 holds the bus
    @(negedge clk);
    req_n = 4'b1110;
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    rst_n = 1'b0;
    #1 check(4'b1111, 1, "async reset");
    @(posedge clk);
    #1 check(4'b1111, 1, "request during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check(4'b1110, 6, "pointer back to agent0 after reset");  // R6
    @(negedge clk) req_n = 4'b1111;
    @(posedge clk);
    #1 check(4'b1110, 7, "agent0 parked after reset");  // R7
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule